// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block turns single-word requests into the strobe sequence of a DRAM whose address pins are shared between a row half and a column half. Each request address is cut into two equal halves. The upper half selects a row and goes out on the shared bus with the row strobe. The lower half selects a column and follows on the same bus with the column strobe. The storage model inside the block is behavioural. Opening a row moves the whole row into a row buffer and clears it in the array, which models a destructive read. For that reason the buffer has to be written back before the row is closed.

The controller keeps the most recently opened row open. A later request to the same row therefore needs only a column phase. A request to a different row first writes back the open row, then activates the new one. A free-running timer raises a refresh request at a fixed interval. At the next idle point the refresh wins over new requests. It closes any open row and then activates and writes back the next row of a round-robin counter.

On the request side, a request is offered with `req_valid` and taken on a clock edge where `req_ready` is also high. Until then the requester holds the request steady. `req_ready` is high only while the controller is idle and no refresh is waiting. Every accepted request produces exactly one single-cycle `rsp_valid` pulse. That pulse cannot be stalled.

Top module: `dram_mux_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `dram_ras`, `dram_cas` and `dram_we` are 0. All storage reads as zero.
- R2: In `req_addr`, the upper HALF_W bits are the row and the lower HALF_W bits are the column. During a row activate, `dram_ras`=1 and `dram_we`=0 with the row on `dram_addr`. During a column phase, `dram_cas`=1 with the column on `dram_addr`. The two strobes are never high together.
- R3: When no row is open, a request takes T_ACT+T_COL cycles from the accept edge to the edge that raises `rsp_valid`.
- R4: A request whose row equals the open row skips the activate and takes T_COL cycles.
- R5: A request to a different row first runs a write-back of the open row for T_WB cycles, with `dram_ras`=1, `dram_we`=1 and the old row on `dram_addr`. It then activates the new row, for a total of T_WB+T_ACT+T_COL cycles.
- R6: `req_op` 0 is a read and 1 is a write. Every response carries the word's value from before the operation, and a write stores `req_wdata`.
- R7: `req_op` 2 is read-modify-write. It returns the old word, stores (old + `req_wdata`) mod 2^DATA_W, and has the same latency as a read to the same row state.
- R8: `req_ready` is 0 whenever the controller is busy. A request held on the port is taken only once `req_ready` returns, and it is then served correctly.
- R9: A refresh is raised every REF_INTERVAL cycles. Successive refreshes activate rows 0, 1, 2, … in order, wrapping after the last row. Each refresh is an activate followed by a write-back of that row.
- R10: A pending refresh forces `req_ready` to 0. If a row is open, that row is written back before the refresh row is activated.
- R11: Stored data survives destructive row opens, row changes and refreshes.
- R12: `rsp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write |
| req_addr | input | 2*HALF_W | Word address, row in upper half |
| req_wdata | input | DATA_W | Write data or addend |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Word value before the operation |
| dram_addr | output | HALF_W | Shared row/column address bus |
| dram_ras | output | 1 | Row strobe (activate or write-back) |
| dram_cas | output | 1 | Column strobe |
| dram_we | output | 1 | Row write-back in progress |

## Verification
A response is due T_COL, T_ACT+T_COL or T_WB+T_ACT+T_COL cycles after the accept edge, for an open-row hit, a closed row and a row change respectively. The bench counts falling edges from the accept edge up to the first sample that shows `rsp_valid`, and compares that count with the latency class it expects for each vector. Strobe addresses are sampled on every falling edge in between. Refresh activates are timed by cycle count against REF_INTERVAL, and the row they carry is checked against the round-robin order.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2
  } dmc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_COL  = 2'd2,
    ST_WB   = 2'd3
  } dmc_state_e;

  typedef enum logic {
    MODE_REQ = 1'b0,
    MODE_REF = 1'b1
  } dmc_mode_e;
endpackage

// File: rtl/dmc_array.sv
module dmc_array
  import dmc_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_fire,
  input  logic [ROW_W-1:0]  act_row,
  input  logic              wb_fire,
  input  logic [ROW_W-1:0]  wb_row,
  input  logic              col_fire,
  input  logic [COL_W-1:0]  col,
  input  dmc_op_e           op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);
  localparam int ROWS = 1 << ROW_W;
  localparam int COLS = 1 << COL_W;

  logic [DATA_W-1:0] cells  [ROWS][COLS];
  logic [DATA_W-1:0] rowbuf [COLS];

  assign rd_word = rowbuf[col];

  // Opening a row empties it in the array: only a write-back restores it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          cells[r][c] <= '0;
      for (int c = 0; c < COLS; c++)
        rowbuf[c] <= '0;
    end else begin
      if (act_fire) begin
        for (int c = 0; c < COLS; c++) begin
          rowbuf[c]        <= cells[act_row][c];
          cells[act_row][c] <= '0;
        end
      end
      if (wb_fire) begin
        for (int c = 0; c < COLS; c++)
          cells[wb_row][c] <= rowbuf[c];
      end
      if (col_fire) begin
        case (op)
          OP_WRITE: rowbuf[col] <= wdata;
          OP_RMW:   rowbuf[col] <= rowbuf[col] + wdata;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dmc_refresh.sv
module dmc_refresh #(
  parameter int ROW_W        = 3,
  parameter int REF_INTERVAL = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_done,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);
  localparam int TMR_W = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(REF_INTERVAL - 1);

  logic [TMR_W-1:0] tmr_q;
  logic             fire;

  assign fire = (tmr_q == TMR_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q    <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      tmr_q <= fire ? '0 : tmr_q + 1'b1;
      if (ref_done) ref_row <= ref_row + 1'b1;
      if (fire) ref_pend <= 1'b1;
      else if (ref_done) ref_pend <= 1'b0;
    end
  end

  assert_ref_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> (ref_row == ROW_W'($past(ref_row) + 1'b1)));
endmodule

// File: rtl/dmc_seq.sv
module dmc_seq
  import dmc_pkg::*;
#(
  parameter int HALF_W = 3,
  parameter int DATA_W = 8,
  parameter int T_ACT  = 3,
  parameter int T_COL  = 1,
  parameter int T_WB   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  dmc_op_e             req_op,
  input  logic [2*HALF_W-1:0] req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  input  logic                ref_pend,
  input  logic [HALF_W-1:0]   ref_row,
  output logic                ref_done,
  output logic                act_fire,
  output logic [HALF_W-1:0]   act_row,
  output logic                wb_fire,
  output logic [HALF_W-1:0]   wb_row,
  output logic                col_fire,
  output logic [HALF_W-1:0]   col,
  output dmc_op_e             op,
  output logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W-1:0]   rd_word,
  output logic [HALF_W-1:0]   dram_addr,
  output logic                dram_ras,
  output logic                dram_cas,
  output logic                dram_we
);
  localparam int MAX_LAT = (T_ACT > T_WB) ? ((T_ACT > T_COL) ? T_ACT : T_COL)
                                          : ((T_WB > T_COL) ? T_WB : T_COL);
  localparam int CNT_W = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1;

  dmc_state_e         state_q;
  dmc_mode_e          mode_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               open_q, chain_q;
  logic [HALF_W-1:0]  open_row_q, row_q, col_q;
  dmc_op_e            op_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               phase_end, accept, row_hit;
  logic [HALF_W-1:0]  in_row;

  assign in_row    = req_addr[2*HALF_W-1:HALF_W];
  assign phase_end = (cnt_q == '0);
  assign req_ready = (state_q == ST_IDLE) && !ref_pend;
  assign accept    = req_valid && req_ready;
  assign row_hit   = open_q && (open_row_q == in_row);

  assign act_row  = (mode_q == MODE_REF) ? ref_row : row_q;
  assign wb_row   = open_row_q;
  assign col      = col_q;
  assign op       = op_q;
  assign wdata    = wdata_q;
  assign act_fire = (state_q == ST_ACT) && phase_end;
  assign col_fire = (state_q == ST_COL) && phase_end;
  assign wb_fire  = (state_q == ST_WB)  && phase_end;
  assign ref_done = wb_fire && (mode_q == MODE_REF) && !chain_q;

  always_comb begin
    dram_ras  = 1'b0;
    dram_cas  = 1'b0;
    dram_we   = 1'b0;
    dram_addr = '0;
    case (state_q)
      ST_ACT: begin dram_ras = 1'b1; dram_addr = act_row; end
      ST_COL: begin dram_cas = 1'b1; dram_addr = col_q; end
      ST_WB:  begin dram_ras = 1'b1; dram_we = 1'b1; dram_addr = open_row_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mode_q     <= MODE_REQ;
      cnt_q      <= '0;
      open_q     <= 1'b0;
      chain_q    <= 1'b0;
      open_row_q <= '0;
      row_q      <= '0;
      col_q      <= '0;
      op_q       <= OP_READ;
      wdata_q    <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (ref_pend) begin
            mode_q <= MODE_REF;
            if (open_q) begin
              state_q <= ST_WB; chain_q <= 1'b1; cnt_q <= CNT_W'(T_WB - 1);
            end else begin
              state_q <= ST_ACT; cnt_q <= CNT_W'(T_ACT - 1);
            end
          end else if (accept) begin
            mode_q  <= MODE_REQ;
            row_q   <= in_row;
            col_q   <= req_addr[HALF_W-1:0];
            op_q    <= req_op;
            wdata_q <= req_wdata;
            if (row_hit) begin
              state_q <= ST_COL; cnt_q <= CNT_W'(T_COL - 1);
            end else if (open_q) begin
              state_q <= ST_WB; chain_q <= 1'b1; cnt_q <= CNT_W'(T_WB - 1);
            end else begin
              state_q <= ST_ACT; cnt_q <= CNT_W'(T_ACT - 1);
            end
          end
        end
        ST_ACT: begin
          if (phase_end) begin
            open_q     <= 1'b1;
            open_row_q <= act_row;
            if (mode_q == MODE_REF) begin
              state_q <= ST_WB; chain_q <= 1'b0; cnt_q <= CNT_W'(T_WB - 1);
            end else begin
              state_q <= ST_COL; cnt_q <= CNT_W'(T_COL - 1);
            end
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_COL: begin
          if (phase_end) begin
            rsp_valid <= 1'b1;
            rsp_data  <= rd_word;
            state_q   <= ST_IDLE;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_WB: begin
          if (phase_end) begin
            open_q <= 1'b0;
            if (chain_q) begin
              state_q <= ST_ACT; chain_q <= 1'b0; cnt_q <= CNT_W'(T_ACT - 1);
            end else state_q <= ST_IDLE;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(dram_ras && dram_cas));
  assert_cas_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dram_cas |-> open_q);
  assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!dram_ras && !dram_cas && !dram_we));
  assert_act_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_ACT) && $past(state_q == ST_IDLE)) |-> !open_q);
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
  import dmc_pkg::*;
#(
  parameter int HALF_W       = 3,
  parameter int DATA_W       = 8,
  parameter int T_ACT        = 3,
  parameter int T_COL        = 1,
  parameter int T_WB         = 2,
  parameter int REF_INTERVAL = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_op,
  input  logic [2*HALF_W-1:0] req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic [HALF_W-1:0]   dram_addr,
  output logic                dram_ras,
  output logic                dram_cas,
  output logic                dram_we
);
  logic              ref_pend, ref_done;
  logic [HALF_W-1:0] ref_row, act_row, wb_row, col;
  logic              act_fire, wb_fire, col_fire;
  dmc_op_e           op;
  logic [DATA_W-1:0] wdata, rd_word;

  dmc_refresh #(.ROW_W(HALF_W), .REF_INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_done(ref_done),
    .ref_pend(ref_pend), .ref_row(ref_row)
  );

  dmc_seq #(.HALF_W(HALF_W), .DATA_W(DATA_W), .T_ACT(T_ACT),
            .T_COL(T_COL), .T_WB(T_WB)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(dmc_op_e'(req_op)),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ref_pend(ref_pend), .ref_row(ref_row), .ref_done(ref_done),
    .act_fire(act_fire), .act_row(act_row), .wb_fire(wb_fire), .wb_row(wb_row),
    .col_fire(col_fire), .col(col), .op(op), .wdata(wdata), .rd_word(rd_word),
    .dram_addr(dram_addr), .dram_ras(dram_ras), .dram_cas(dram_cas),
    .dram_we(dram_we)
  );

  dmc_array #(.ROW_W(HALF_W), .COL_W(HALF_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .act_fire(act_fire), .act_row(act_row),
    .wb_fire(wb_fire), .wb_row(wb_row),
    .col_fire(col_fire), .col(col), .op(op), .wdata(wdata),
    .rd_word(rd_word)
  );
endmodule

// File: tb/tb_dram_mux_ctrl.sv
module tb_dram_mux_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_W = 3;
  localparam int DATA_W = 8;
  localparam int T_ACT = 3, T_COL = 1, T_WB = 2;
  localparam int REF_INTERVAL = 400;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [1:0] op;
    logic [5:0] addr;
    logic [7:0] wd;
    logic [7:0] exp;
    logic [3:0] lat;
  } vec_t;

  // latency 4 = closed row, 1 = open-row hit, 6 = row change
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 6'h0A, 8'h5C, 8'h00, 4'd4},
    '{2'd0, 6'h0A, 8'h00, 8'h5C, 4'd1},
    '{2'd2, 6'h0A, 8'h10, 8'h5C, 4'd1},
    '{2'd1, 6'h0B, 8'hA3, 8'h00, 4'd1},
    '{2'd0, 6'h22, 8'h00, 8'h00, 4'd6},
    '{2'd1, 6'h22, 8'hF0, 8'h00, 4'd1},
    '{2'd0, 6'h0A, 8'h00, 8'h6C, 4'd6},
    '{2'd0, 6'h0B, 8'h00, 8'hA3, 4'd1},
    '{2'd2, 6'h0B, 8'h70, 8'hA3, 4'd1},
    '{2'd0, 6'h22, 8'h00, 8'hF0, 4'd6},
    '{2'd0, 6'h3F, 8'h00, 8'h00, 4'd6},
    '{2'd2, 6'h3F, 8'hFF, 8'h00, 4'd1},
    '{2'd0, 6'h3F, 8'h00, 8'hFF, 4'd1},
    '{2'd0, 6'h0B, 8'h00, 8'h13, 4'd6}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = 2'd0;
  logic [5:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic rsp_valid;
  logic [7:0] rsp_data;
  logic [2:0] dram_addr;
  logic dram_ras, dram_cas, dram_we;

  int checks = 0, fails = 0, cyc = 0;
  logic done = 1'b0;
  logic [2:0] prev_row = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_mux_ctrl #(.HALF_W(HALF_W), .DATA_W(DATA_W), .T_ACT(T_ACT), .T_COL(T_COL),
                  .T_WB(T_WB), .REF_INTERVAL(REF_INTERVAL)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .dram_addr(dram_addr),
    .dram_ras(dram_ras), .dram_cas(dram_cas), .dram_we(dram_we)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Issues one request; returns data, latency (edges accept->rsp) and port-level flags.
  task automatic do_req(input logic [1:0] op, input logic [5:0] addr, input logic [7:0] wd,
                        output logic [7:0] data, output int lat,
                        output bit addr_ok, output bit busy_ok, output bit pulse_ok,
                        output bit wb_seen, output logic [2:0] wb_addr);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = !req_ready;
    addr_ok = 1'b1; wb_seen = 1'b0; wb_addr = '0;
    n = 1;
    while (!rsp_valid && n < 40) begin
      if (dram_cas && dram_addr != addr[2:0]) addr_ok = 1'b0;
      if (dram_ras && dram_cas) addr_ok = 1'b0;
      if (dram_ras && !dram_we && dram_addr != addr[5:3]) addr_ok = 1'b0;
      if (dram_ras && dram_we) begin wb_seen = 1'b1; wb_addr = dram_addr; end
      @(negedge clk);
      n++;
    end
    data = rsp_data;
    lat = n - 1;
    @(negedge clk);
    pulse_ok = !rsp_valid;
  endtask

  initial begin
    logic [7:0] d;
    int lat;
    bit a_ok, b_ok, p_ok, wbs;
    logic [2:0] wba;
    string lt;
    int last_wb, ref_cyc [10];
    bit prev_act;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(req_ready && !rsp_valid && !dram_ras && !dram_cas && !dram_we, "R1 reset outputs",
          {req_ready, rsp_valid, dram_ras, dram_cas, dram_we}, 5'b10000);

    for (int i = 0; i < NVEC; i++) begin
      do_req(VECS[i].op, VECS[i].addr, VECS[i].wd, d, lat, a_ok, b_ok, p_ok, wbs, wba);
      lt = (VECS[i].lat == 4'd1) ? "R4 hit latency" :
           (VECS[i].lat == 4'd4) ? "R3 closed latency" : "R5 miss latency";
      check(lat == int'(VECS[i].lat), lt, lat, VECS[i].lat);
      check(d == VECS[i].exp, (VECS[i].op == 2'd2) ? "R7 rmw data" : "R6 R11 data",
            d, VECS[i].exp);
      check(a_ok, "R2 address halves", 0, 1);
      check(b_ok && p_ok, "R8 R12 busy and pulse", {b_ok, p_ok}, 2'b11);
      if (VECS[i].lat == 4'd6)
        check(wbs && wba == prev_row, "R5 write-back of old row", wba, prev_row);
      prev_row = VECS[i].addr[5:3];
    end

    // R9 R10: refresh order, spacing, closing of the open row (row 1)
    last_wb = -1;
    prev_act = 1'b0;
    for (int k = 0; k < 10; k++) begin
      forever begin
        @(negedge clk);
        if (dram_ras && dram_we) last_wb = dram_addr;
        if (dram_ras && !dram_we && !prev_act) begin prev_act = 1'b1; break; end
        prev_act = dram_ras && !dram_we;
      end
      ref_cyc[k] = cyc;
      check(dram_addr == 3'(k % 8), "R9 refresh row order", dram_addr, k % 8);
      if (k == 0) begin
        check(last_wb == 1, "R10 open row closed first", last_wb, 1);
        check(!req_ready, "R10 ready low during refresh", req_ready, 0);
      end
      if (k == 2)
        check(ref_cyc[2] - ref_cyc[1] == REF_INTERVAL, "R9 refresh interval",
              ref_cyc[2] - ref_cyc[1], REF_INTERVAL);
    end

    // R8 R11: request held during refresh, then served from a closed row
    do_req(2'd0, 6'h0B, 8'h00, d, lat, a_ok, b_ok, p_ok, wbs, wba);
    check(d == 8'h13, "R8 R11 data after refresh", d, 8'h13);
    check(lat == T_ACT + T_COL, "R3 latency after refresh closed row", lat, T_ACT + T_COL);
    do_req(2'd0, 6'h22, 8'h00, d, lat, a_ok, b_ok, p_ok, wbs, wba);
    check(d == 8'hF0 && lat == T_WB + T_ACT + T_COL, "R11 R5 data after refreshes",
          {d, 8'(lat)}, {8'hF0, 8'(T_WB + T_ACT + T_COL)});

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule